// File: doc/BRIEF.md
# Duplex mirrored memory manager

This block sits between a processor and a bank of up to eight word-organised storage modules of 4096 words each. The processor sends one request at a time: an address, a write flag, 26 bits of write data and a per-request mode bit. In simplex mode every module holds distinct data, so the full 32K-word space can be addressed. In duplex mode the modules work as pairs. Every word is kept twice, which halves the space to 16K words.

Each stored word carries two odd-parity bits, one for each 13-bit half (syllable). On a write the manager produces these bits. On a read it checks them. A duplex read fetches both copies of the word together. The primary copy is returned when its parity is good. When the primary copy is bad and the mirror copy is good, the mirror copy is returned and a counter of mirror-served reads is incremented. When both copies are bad, the primary data is returned with an uncorrectable flag. A duplex address beyond the 16K range touches no module and returns an address error.

Requests and responses follow a fixed two-cycle pipeline. The module ports are combinational from the request, and the modules return read data one cycle after they are enabled.

Top module: `dup_mem_mgr`

## Requirements
- R1: In simplex mode, the module with index req_addr[14:12] is enabled alone, at word address req_addr[11:0].
- R2: In duplex mode, pair k = req_addr[13:12] uses module 2k as primary and module 2k+1 as mirror. Reads and writes enable both modules in the same cycle, with the same word address req_addr[11:0] and, for writes, the same data.
- R3: A stored word holds data in bits [25:0]. Bit 26 is the odd-parity bit over bits [12:0], and bit 27 is the odd-parity bit over bits [25:13].
- R4: A duplex read whose primary copy has good parity returns the primary data, with resp_from_mirror=0 and resp_uncorr=0.
- R5: A duplex read whose primary copy fails parity and whose mirror copy passes returns the mirror data, with resp_from_mirror=1 and resp_uncorr=0.
- R6: A duplex read in which both copies fail parity returns the primary data bits as stored, with resp_uncorr=1 and resp_from_mirror=0.
- R7: A simplex read that fails parity returns the stored data bits, with resp_uncorr=1.
- R8: A duplex request with req_addr[14]=1 enables no module, so a write of this kind changes no stored word. Its response carries resp_addr_err=1.
- R9: mirror_reads is 0 after reset. It increments by one for each R5 response and saturates at its all-ones value.
- R10: Every request produces resp_valid exactly two clock edges after the edge that accepts it, and never on the edge in between. After reset, resp_valid and all module enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_duplex | input | 1 | 1 = mirrored (pair) mode, 0 = single-copy mode |
| req_addr | input | 15 | Word address |
| req_wdata | input | 26 | Write data |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | 26 | Read data |
| resp_from_mirror | output | 1 | Read was served from the mirror copy |
| resp_uncorr | output | 1 | No copy with good parity was found |
| resp_addr_err | output | 1 | Duplex address out of range |
| mirror_reads | output | CNT_W (16) | Saturating count of mirror-served reads |
| mod_en | output | 8 | Per-module enable |
| mod_we | output | 1 | Write strobe shared by the enabled modules |
| mod_addr | output | 12 | Word address within a module |
| mod_wdata | output | 28 | Stored word with parity |
| mod_rdata | input | 224 | Read word of each module, 28 bits per module, valid one cycle after its enable |

## Verification
On every cycle the assertions check four things. Module enables are one-hot for simplex requests, form the correct pair for in-range duplex requests, and are all off for out-of-range ones. The response arrives on the second edge. The mirror and uncorrectable flags never appear together. The mirror counter moves only on mirror-served responses. Which copy is actually returned, the parity layout of the stored words, and the blocking of a rejected write are shown only by the bench's scenarios. These scenarios corrupt chosen copies in a module model and then read the words back.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  // Source chosen for a read response
  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_PRIMARY = 2'd1,
    PICK_MIRROR  = 2'd2,
    PICK_FAILED  = 2'd3
  } pick_e;
endpackage

// File: rtl/dmm_rst_sync.sv
module dmm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= 2'b00;
    else         sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/dmm_addr_map.sv
module dmm_addr_map #(
  parameter  int N_MOD  = 8,
  parameter  int MOD_AW = 12,
  localparam int SEL_W  = $clog2(N_MOD),
  localparam int AW     = SEL_W + MOD_AW
) (
  input  logic [AW-1:0]    addr,
  input  logic             duplex,
  output logic [SEL_W-1:0] prim_idx,
  output logic [SEL_W-1:0] mirr_idx,
  output logic             addr_err
);
  // Duplex pairs are (2k, 2k+1); the top address bit is out of range
  always_comb begin
    if (duplex) begin
      prim_idx = {addr[AW-2:MOD_AW], 1'b0};
      mirr_idx = {addr[AW-2:MOD_AW], 1'b1};
      addr_err = addr[AW-1];
    end else begin
      prim_idx = addr[AW-1:MOD_AW];
      mirr_idx = addr[AW-1:MOD_AW];
      addr_err = 1'b0;
    end
  end
endmodule

// File: rtl/dmm_parity.sv
module dmm_parity #(
  parameter  int SYL_W  = 13,
  parameter  int N_SYL  = 2,
  localparam int WORD_W = SYL_W * N_SYL
) (
  input  logic [WORD_W-1:0] data,
  output logic [N_SYL-1:0]  par
);
  // Odd parity: each syllable together with its bit has an odd count of ones
  for (genvar g = 0; g < N_SYL; g++) begin : g_syl
    assign par[g] = ~^data[g*SYL_W +: SYL_W];
  end
endmodule

// File: rtl/dup_mem_mgr.sv
module dup_mem_mgr
  import dmm_pkg::*;
#(
  parameter  int N_MOD   = 8,
  parameter  int MOD_AW  = 12,
  parameter  int SYL_W   = 13,
  parameter  int N_SYL   = 2,
  parameter  int CNT_W   = 16,
  localparam int SEL_W   = $clog2(N_MOD),
  localparam int AW      = SEL_W + MOD_AW,
  localparam int WORD_W  = SYL_W * N_SYL,
  localparam int STORE_W = WORD_W + N_SYL
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_duplex,
  input  logic [AW-1:0]            req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     resp_valid,
  output logic [WORD_W-1:0]        resp_rdata,
  output logic                     resp_from_mirror,
  output logic                     resp_uncorr,
  output logic                     resp_addr_err,
  output logic [CNT_W-1:0]         mirror_reads,
  output logic [N_MOD-1:0]         mod_en,
  output logic                     mod_we,
  output logic [MOD_AW-1:0]        mod_addr,
  output logic [STORE_W-1:0]       mod_wdata,
  input  logic [N_MOD*STORE_W-1:0] mod_rdata
);
  logic rst_n_q;

  dmm_rst_sync i_rst (.clk(clk), .arst_n(rst_n), .rst_n_sync(rst_n_q));

  // ---------------- request decode (combinational to modules)
  logic [SEL_W-1:0] dec_prim, dec_mirr;
  logic             dec_err;
  logic [N_SYL-1:0] wr_par;

  dmm_addr_map #(.N_MOD(N_MOD), .MOD_AW(MOD_AW)) i_map (
    .addr(req_addr), .duplex(req_duplex),
    .prim_idx(dec_prim), .mirr_idx(dec_mirr), .addr_err(dec_err)
  );

  dmm_parity #(.SYL_W(SYL_W), .N_SYL(N_SYL)) i_wpar (.data(req_wdata), .par(wr_par));

  always_comb begin
    mod_en = '0;
    if (req_valid && !dec_err) begin
      mod_en[dec_prim] = 1'b1;
      if (req_duplex) mod_en[dec_mirr] = 1'b1;
    end
  end

  assign mod_we    = req_valid && req_write && !dec_err;
  assign mod_addr  = req_addr[MOD_AW-1:0];
  assign mod_wdata = {wr_par, req_wdata};

  // ---------------- stage 1: request context while modules read
  logic             s1_valid_q, s1_write_q, s1_duplex_q, s1_err_q;
  logic [SEL_W-1:0] s1_prim_q, s1_mirr_q;

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      s1_valid_q  <= 1'b0;
      s1_write_q  <= 1'b0;
      s1_duplex_q <= 1'b0;
      s1_err_q    <= 1'b0;
      s1_prim_q   <= '0;
      s1_mirr_q   <= '0;
    end else begin
      s1_valid_q <= req_valid;
      if (req_valid) begin
        s1_write_q  <= req_write;
        s1_duplex_q <= req_duplex;
        s1_err_q    <= dec_err;
        s1_prim_q   <= dec_prim;
        s1_mirr_q   <= dec_mirr;
      end
    end
  end

  // ---------------- copy selection
  logic [STORE_W-1:0] prim_word, mirr_word;
  logic [N_SYL-1:0]   prim_par, mirr_par;
  logic               prim_ok, mirr_ok;
  pick_e              pick;

  assign prim_word = mod_rdata[s1_prim_q*STORE_W +: STORE_W];
  assign mirr_word = mod_rdata[s1_mirr_q*STORE_W +: STORE_W];

  dmm_parity #(.SYL_W(SYL_W), .N_SYL(N_SYL)) i_ppar (.data(prim_word[WORD_W-1:0]), .par(prim_par));
  dmm_parity #(.SYL_W(SYL_W), .N_SYL(N_SYL)) i_mpar (.data(mirr_word[WORD_W-1:0]), .par(mirr_par));

  assign prim_ok = (prim_word[STORE_W-1:WORD_W] == prim_par);
  assign mirr_ok = (mirr_word[STORE_W-1:WORD_W] == mirr_par);

  always_comb begin
    if (!s1_valid_q || s1_write_q || s1_err_q) pick = PICK_NONE;
    else if (prim_ok)                          pick = PICK_PRIMARY;
    else if (s1_duplex_q && mirr_ok)           pick = PICK_MIRROR;
    else                                       pick = PICK_FAILED;
  end

  // ---------------- stage 2: response next-state
  logic [WORD_W-1:0] rdata_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              cnt_en;

  always_comb begin
    case (pick)
      PICK_MIRROR:               rdata_n = mirr_word[WORD_W-1:0];
      PICK_PRIMARY, PICK_FAILED: rdata_n = prim_word[WORD_W-1:0];
      default:                   rdata_n = '0;
    endcase
    cnt_en = (pick == PICK_MIRROR) && (mirror_reads != {CNT_W{1'b1}});
    cnt_n  = mirror_reads + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      resp_valid       <= 1'b0;
      resp_rdata       <= '0;
      resp_from_mirror <= 1'b0;
      resp_uncorr      <= 1'b0;
      resp_addr_err    <= 1'b0;
      mirror_reads     <= '0;
    end else begin
      resp_valid       <= s1_valid_q;
      resp_from_mirror <= (pick == PICK_MIRROR);
      resp_uncorr      <= (pick == PICK_FAILED);
      resp_addr_err    <= s1_valid_q && s1_err_q;
      if (s1_valid_q) resp_rdata   <= rdata_n;
      if (cnt_en)     mirror_reads <= cnt_n;
    end
  end
endmodule

// File: rtl/dmm_chk.sv
module dmm_chk #(
  parameter  int N_MOD  = 8,
  parameter  int MOD_AW = 12,
  parameter  int CNT_W  = 16,
  localparam int SEL_W  = $clog2(N_MOD),
  localparam int AW     = SEL_W + MOD_AW
) (
  input logic             clk,
  input logic             rst_n_q,
  input logic             req_valid,
  input logic             req_duplex,
  input logic [AW-1:0]    req_addr,
  input logic             resp_valid,
  input logic             resp_from_mirror,
  input logic             resp_uncorr,
  input logic             resp_addr_err,
  input logic [CNT_W-1:0] mirror_reads,
  input logic [N_MOD-1:0] mod_en
);
  // R1
  simplex_single_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_valid && !req_duplex |-> $countones(mod_en) == 1 && mod_en[req_addr[AW-1:MOD_AW]]);

  // R2
  duplex_pair_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_valid && req_duplex && !req_addr[AW-1] |->
      $countones(mod_en) == 2 && mod_en[{req_addr[AW-2:MOD_AW], 1'b0}]
      && mod_en[{req_addr[AW-2:MOD_AW], 1'b1}]);

  // R8
  range_block_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_valid && req_duplex && req_addr[AW-1] |-> mod_en == '0);

  // R8
  range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_valid && req_duplex && req_addr[AW-1] |=> ##1 (resp_valid && resp_addr_err));

  // R10
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_valid |=> !resp_valid ##1 resp_valid);

  // R10
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !req_valid |=> ##1 !resp_valid);

  // R5
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    resp_valid |-> !(resp_from_mirror && resp_uncorr));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    resp_valid && resp_from_mirror && $past(mirror_reads) != {CNT_W{1'b1}} |->
      mirror_reads == CNT_W'($past(mirror_reads) + 1'b1));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(resp_valid && resp_from_mirror) |-> $stable(mirror_reads));
endmodule

bind dup_mem_mgr dmm_chk #(.N_MOD(N_MOD), .MOD_AW(MOD_AW), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n_q(rst_n_q), .req_valid(req_valid), .req_duplex(req_duplex),
  .req_addr(req_addr), .resp_valid(resp_valid), .resp_from_mirror(resp_from_mirror),
  .resp_uncorr(resp_uncorr), .resp_addr_err(resp_addr_err),
  .mirror_reads(mirror_reads), .mod_en(mod_en)
);

// File: tb/test_dup_mem_mgr.sv
`timescale 1ns/1ps
module test_dup_mem_mgr;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, req_duplex;
  logic [14:0]   req_addr;
  logic [25:0]   req_wdata;
  logic          resp_valid, resp_from_mirror, resp_uncorr, resp_addr_err;
  logic [25:0]   resp_rdata;
  logic [CW-1:0] mirror_reads;
  logic [7:0]    mod_en;
  logic          mod_we;
  logic [11:0]   mod_addr;
  logic [27:0]   mod_wdata;
  logic [223:0]  mod_rdata;

  always #10 clk = ~clk;

  dup_mem_mgr #(.CNT_W(CW)) i_dup_mem_mgr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_duplex(req_duplex), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_from_mirror(resp_from_mirror),
    .resp_uncorr(resp_uncorr), .resp_addr_err(resp_addr_err), .mirror_reads(mirror_reads),
    .mod_en(mod_en), .mod_we(mod_we), .mod_addr(mod_addr), .mod_wdata(mod_wdata),
    .mod_rdata(mod_rdata)
  );

  // ---- storage module model: registered read, one cycle after enable
  logic [27:0] mem [int];
  logic [27:0] rd [8];

  initial for (int i = 0; i < 8; i++) rd[i] = '0;

  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (mod_en[i]) begin
        int k;
        k = i * 4096 + int'(mod_addr);
        if (mod_we) mem[k] = mod_wdata;
        else        rd[i] <= mem.exists(k) ? mem[k] : 28'h0;
      end
    end
  end

  always_comb for (int i = 0; i < 8; i++) mod_rdata[i*28 +: 28] = rd[i];

  // ---- checking
  int n_chk = 0, n_bad = 0;
  int exp_cnt = 0;
  logic [7:0] en_seen;
  logic       we_seen;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic dup, input logic [14:0] a, input logic [25:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_duplex = dup; req_addr = a; req_wdata = d;
    #1 en_seen = mod_en; we_seen = mod_we;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 no response one edge after request", 32'(resp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 response two edges after request", 32'(resp_valid), 1);
  endtask

  function automatic int prim_of(input logic dup, input logic [14:0] a);
    return dup ? 2 * int'(a[13:12]) : int'(a[14:12]);
  endfunction

  function automatic logic [27:0] stored(input logic [25:0] d);
    return {~^d[25:13], ~^d[12:0], d};
  endfunction

  function automatic int sat(input int v);
    return (v >= (1 << CW) - 1) ? (1 << CW) - 1 : v + 1;
  endfunction

  // ---- stimulus table: mode, address, data, corruption {mirror, primary}
  typedef struct packed {
    logic        dup;
    logic [14:0] addr;
    logic [25:0] data;
    logic [1:0]  cor;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 15'h0005, 26'h1234567, 2'b00},
    '{1'b0, 15'h7FFF, 26'h3FFFFFF, 2'b00},
    '{1'b0, 15'h3ABC, 26'h0000000, 2'b01},
    '{1'b1, 15'h0000, 26'h2ABCDEF, 2'b00},
    '{1'b1, 15'h3FFF, 26'h1FEDCBA, 2'b01},
    '{1'b1, 15'h2345, 26'h0F0F0F0, 2'b10},
    '{1'b1, 15'h1111, 26'h3333333, 2'b11},
    '{1'b1, 15'h1C00, 26'h0000001, 2'b01}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    req_valid = 0; req_write = 0; req_duplex = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset resp_valid", 32'(resp_valid), 0);
    chk("R9 reset counter", 32'(mirror_reads), 0);
    chk("R10 reset enables", 32'(mod_en), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // ---- table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int p, w, kp, km;
      logic [25:0] exp_d;
      t  = VEC[v];
      p  = prim_of(t.dup, t.addr);
      w  = int'(t.addr[11:0]);
      kp = p * 4096 + w;
      km = (p + 1) * 4096 + w;

      do_req(1'b1, t.dup, t.addr, t.data);
      if (t.dup) chk("R2 pair enables on write", 32'(en_seen), 32'((8'b11) << p));
      else       chk("R1 single enable on write", 32'(en_seen), 32'(8'b1 << p));
      chk("R8 write in range no address error", 32'(resp_addr_err), 0);
      chk("R3 primary stored word", 32'(mem[kp]), 32'(stored(t.data)));
      if (t.dup) chk("R2 mirror stored word", 32'(mem[km]), 32'(stored(t.data)));

      if (t.cor[0]) mem[kp] = mem[kp] ^ 28'h0000001;
      if (t.cor[1]) mem[km] = mem[km] ^ 28'h0002000;

      do_req(1'b0, t.dup, t.addr, 26'h0);
      exp_d = t.data;
      if (!t.dup) begin
        chk("R7 simplex uncorrectable flag", 32'(resp_uncorr), 32'(t.cor[0]));
        if (t.cor[0]) exp_d = t.data ^ 26'h1;
        chk("R7/R1 simplex read data", 32'(resp_rdata), 32'(exp_d));
      end else if (!t.cor[0]) begin
        chk("R4 primary data", 32'(resp_rdata), 32'(t.data));
        chk("R4 not from mirror", 32'(resp_from_mirror), 0);
        chk("R4 no uncorrectable", 32'(resp_uncorr), 0);
      end else if (!t.cor[1]) begin
        exp_cnt = sat(exp_cnt);
        chk("R5 mirror data", 32'(resp_rdata), 32'(t.data));
        chk("R5 from mirror flag", 32'(resp_from_mirror), 1);
        chk("R5 no uncorrectable", 32'(resp_uncorr), 0);
      end else begin
        chk("R6 corrupted primary data", 32'(resp_rdata), 32'(t.data ^ 26'h1));
        chk("R6 uncorrectable flag", 32'(resp_uncorr), 1);
        chk("R6 not from mirror", 32'(resp_from_mirror), 0);
      end
      chk("R9 mirror counter", 32'(mirror_reads), 32'(exp_cnt));
    end

    // ---- R8: out-of-range duplex write touches nothing
    do_req(1'b1, 1'b0, 15'h0010, 26'h0ABCDEF);
    do_req(1'b1, 1'b1, 15'h4010, 26'h3000000);
    chk("R8 no module enabled", 32'(en_seen), 0);
    chk("R8 no write strobe", 32'(we_seen), 0);
    chk("R8 address error flag", 32'(resp_addr_err), 1);
    do_req(1'b0, 1'b0, 15'h0010, 26'h0);
    chk("R8 word unchanged after rejected write", 32'(resp_rdata), 32'h0ABCDEF);
    do_req(1'b0, 1'b1, 15'h7010, 26'h0);
    chk("R8 out-of-range read error", 32'(resp_addr_err), 1);
    chk("R8 out-of-range read no enable", 32'(en_seen), 0);

    // ---- R2 read enables both copies
    do_req(1'b0, 1'b1, 15'h2345, 26'h0);
    chk("R2 pair enables on read", 32'(en_seen), 32'h30);

    // ---- R9 saturation: primary at 0x3FFF stays corrupted
    for (int i = 0; i < 8; i++) begin
      do_req(1'b0, 1'b1, 15'h3FFF, 26'h0);
      exp_cnt = sat(exp_cnt);
      chk("R9 saturating counter", 32'(mirror_reads), 32'(exp_cnt));
    end
    chk("R9 counter held at all ones", 32'(mirror_reads), 32'((1 << CW) - 1));
    chk("R5 still served from mirror", 32'(resp_from_mirror), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule